// File: doc/BRIEF.md
# Program Counter and Branch Target Unit

This block keeps the program counter of an 8-bit controller core that has a 16-bit program space. Each cycle in which the core offers an instruction, the block chooses the next fetch address. It forms that address from the already-incremented PC, the instruction's operand bytes, a 3-bit page field taken from the opcode, the accumulator, the data pointer and a taken flag, according to an operation kind. Decoding the opcode and evaluating the branch condition happen upstream. The stack memory sits outside the block.

Subroutine calls, interrupt entries and returns move the PC through the stack one byte at a time. A small sequencer inside the block owns the 8-bit stack pointer and drives the write and read strobes of an external synchronous byte memory. While a transfer is under way, `busy` is high and any offered instruction is ignored.

Operation kinds on `op_kind`:

| Code | Kind |
|---|---|
| 0 | sequential |
| 1 | relative branch |
| 2 | page jump |
| 3 | long jump |
| 4 | indexed jump |
| 5 | page call |
| 6 | long call |
| 7 | return |
| 8 | interrupt entry |

Any other code behaves as sequential.

Top module: `pc_next_unit`

## Requirements
- R1: Relative branch with `taken`=1: one cycle after acceptance, the PC equals `pc_inc` plus `op_b2`. `op_b2` is read as a signed offset from −128 to +127, and the sum wraps modulo 65536.
- R2: Relative branch with `taken`=0: the PC becomes `pc_inc`.
- R3: Page jump (code 2): the PC becomes {`pc_inc`[15:11], `op_page`[2:0], `op_b2`}. Bits 15 to 11 are kept from `pc_inc`.
- R4: Long jump (code 3): the PC becomes {`op_b2`, `op_b3`}, with the second byte as the high byte.
- R5: Indexed jump (code 4): the PC becomes `dptr` + `acc`, modulo 65536.
- R6: Page call (code 5) and long call (code 6) form their targets as in R3 and R4. The low byte of `pc_inc` is written at SP+1 in the first busy cycle, and the high byte at SP+2 in the second. SP rises by one after each write. The PC takes the target at the edge that ends the second write.
- R7: Return (code 7): the high byte is read at SP and then the low byte at SP−1, through a memory with one cycle of read latency. SP falls by one after each read. The PC becomes the restored address three cycles after the return's own edge.
- R8: Interrupt entry (code 8): the block performs the R6 push of `pc_inc` and then jumps to `vec`.
- R9: While `busy` is high, `op_valid` is ignored. The PC and SP change only as the current transfer dictates.
- R10: A synchronous reset sets the PC to 0000h and SP to 07h, and clears `busy`.
- R11: A sequential operation loads `pc_inc`. When `op_valid` is low and the block is idle, the PC holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Instruction offered this cycle |
| op_kind | input | 4 | Operation kind code |
| pc_inc | input | 16 | PC already advanced past the instruction |
| op_page | input | 3 | Page field from the opcode |
| op_b2 | input | 8 | Second instruction byte |
| op_b3 | input | 8 | Third instruction byte |
| acc | input | 8 | Accumulator |
| dptr | input | 16 | Data pointer |
| taken | input | 1 | Relative branch condition |
| vec | input | 16 | Interrupt vector address |
| stk_rdata | input | 8 | Stack read data, one cycle after the read strobe |
| pc_o | output | 16 | Program counter |
| busy | output | 1 | Stack transfer in progress |
| sp_o | output | 8 | Stack pointer |
| stk_we | output | 1 | Stack write strobe |
| stk_re | output | 1 | Stack read strobe |
| stk_addr | output | 8 | Stack byte address |
| stk_wdata | output | 8 | Stack write data |

## Verification
Two functions of this block can fall in the same cycle: a new instruction offered on `op_valid`, and a byte transfer of the stack sequencer that is still running. The bench provokes this by holding a long jump on the inputs during every busy cycle of a call. A cycle-accurate model then judges the result. In that model the PC, SP and `busy` follow only the queued transfer states, so any reaction to the intruding instruction shows up as a mismatch on the next clock. Returns that follow a chain of calls and an interrupt entry confirm that the pushed bytes come back in the right order.

// File: rtl/pnu_pkg.sv
package pnu_pkg;
  typedef enum logic [3:0] {
    K_SEQ   = 4'd0,
    K_REL   = 4'd1,
    K_PAGE  = 4'd2,
    K_LONG  = 4'd3,
    K_INDEX = 4'd4,
    K_CALLP = 4'd5,
    K_CALLL = 4'd6,
    K_RET   = 4'd7,
    K_INTR  = 4'd8
  } op_kind_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_PUSH_LO,
    S_PUSH_HI,
    S_POP_HI,
    S_POP_LO,
    S_POP_END
  } seq_state_e;
endpackage

// File: rtl/pnu_target.sv
module pnu_target
  import pnu_pkg::*;
#(
  parameter int DW     = 8,
  parameter int PAGE_W = 11
) (
  input  op_kind_e                 kind,
  input  logic [2*DW-1:0]          pc_inc,
  input  logic [PAGE_W-DW-1:0]     page_fld,
  input  logic [DW-1:0]            b2,
  input  logic [DW-1:0]            b3,
  input  logic [DW-1:0]            acc,
  input  logic [2*DW-1:0]          dptr,
  input  logic                     taken,
  input  logic [2*DW-1:0]          vec,
  output logic [2*DW-1:0]          tgt
);
  localparam int AW = 2 * DW;

  logic [AW-1:0] rel_sum, page_tgt, long_tgt, idx_sum;

  // relative: sign-extended offset, wrap modulo 2**AW
  assign rel_sum  = pc_inc + {{(AW-DW){b2[DW-1]}}, b2};
  // page form: only the low PAGE_W bits are replaced
  assign page_tgt = {pc_inc[AW-1:PAGE_W], page_fld, b2};
  assign long_tgt = {b2, b3};
  assign idx_sum  = dptr + {{(AW-DW){1'b0}}, acc};

  always_comb begin
    case (kind)
      K_REL:           tgt = taken ? rel_sum : pc_inc;
      K_PAGE, K_CALLP: tgt = page_tgt;
      K_LONG, K_CALLL: tgt = long_tgt;
      K_INDEX:         tgt = idx_sum;
      K_INTR:          tgt = vec;
      default:         tgt = pc_inc;
    endcase
  end
endmodule

// File: rtl/pnu_stack_seq.sv
module pnu_stack_seq
  import pnu_pkg::*;
#(
  parameter int          DW      = 8,
  parameter int          SPW     = 8,
  parameter logic [7:0]  SP_INIT = 8'h07
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start_push,
  input  logic            start_pop,
  input  logic [2*DW-1:0] ret_in,
  input  logic [2*DW-1:0] tgt_in,
  input  logic [DW-1:0]   stk_rdata,
  output logic            busy,
  output logic            load,
  output logic [2*DW-1:0] load_val,
  output logic            stk_we,
  output logic            stk_re,
  output logic [SPW-1:0]  stk_addr,
  output logic [DW-1:0]   stk_wdata,
  output logic [SPW-1:0]  sp
);
  localparam int AW = 2 * DW;

  seq_state_e    state;
  logic [AW-1:0] ret_r, tgt_r;
  logic [DW-1:0] hi_r;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= S_IDLE;
      sp    <= SPW'(SP_INIT);
      ret_r <= '0;
      tgt_r <= '0;
      hi_r  <= '0;
    end else begin
      case (state)
        S_IDLE: begin
          if (start_push) begin
            ret_r <= ret_in;
            tgt_r <= tgt_in;
            state <= S_PUSH_LO;
          end else if (start_pop) begin
            state <= S_POP_HI;
          end
        end
        S_PUSH_LO: begin
          sp    <= sp + SPW'(1);
          state <= S_PUSH_HI;
        end
        S_PUSH_HI: begin
          sp    <= sp + SPW'(1);
          state <= S_IDLE;
        end
        S_POP_HI: begin
          sp    <= sp - SPW'(1);
          state <= S_POP_LO;
        end
        S_POP_LO: begin
          hi_r  <= stk_rdata;
          sp    <= sp - SPW'(1);
          state <= S_POP_END;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    stk_we    = (state == S_PUSH_LO) || (state == S_PUSH_HI);
    stk_re    = (state == S_POP_HI)  || (state == S_POP_LO);
    stk_addr  = stk_we ? sp + SPW'(1) : sp;
    stk_wdata = (state == S_PUSH_LO) ? ret_r[DW-1:0] : ret_r[AW-1:DW];
    load      = (state == S_PUSH_HI) || (state == S_POP_END);
    load_val  = (state == S_PUSH_HI) ? tgt_r : {hi_r, stk_rdata};
    busy      = (state != S_IDLE);
  end

  // R6: low byte write is followed by the high byte write, SP one higher
  p_push_order_r6: assert property (@(posedge clk) disable iff (rst)
    (state == S_PUSH_LO) |=> (state == S_PUSH_HI && sp == $past(sp) + SPW'(1)));

  // R7: the high byte read is followed by the low byte read, SP one lower
  p_pop_order_r7: assert property (@(posedge clk) disable iff (rst)
    (state == S_POP_HI) |=> (state == S_POP_LO && sp == $past(sp) - SPW'(1)));

  // R9: a push cannot start from the middle of a pop
  p_no_restart_r9: assert property (@(posedge clk) disable iff (rst)
    (state == S_POP_LO) |=> (state == S_POP_END));
endmodule

// File: rtl/pc_next_unit.sv
module pc_next_unit
  import pnu_pkg::*;
#(
  parameter int          DW      = 8,
  parameter int          SPW     = 8,
  parameter int          PAGE_W  = 11,
  parameter logic [7:0]  SP_INIT = 8'h07
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  op_valid,
  input  logic [3:0]            op_kind,
  input  logic [2*DW-1:0]       pc_inc,
  input  logic [PAGE_W-DW-1:0]  op_page,
  input  logic [DW-1:0]         op_b2,
  input  logic [DW-1:0]         op_b3,
  input  logic [DW-1:0]         acc,
  input  logic [2*DW-1:0]       dptr,
  input  logic                  taken,
  input  logic [2*DW-1:0]       vec,
  input  logic [DW-1:0]         stk_rdata,
  output logic [2*DW-1:0]       pc_o,
  output logic                  busy,
  output logic [SPW-1:0]        sp_o,
  output logic                  stk_we,
  output logic                  stk_re,
  output logic [SPW-1:0]        stk_addr,
  output logic [DW-1:0]         stk_wdata
);
  localparam int AW = 2 * DW;

  op_kind_e      kind;
  logic [AW-1:0] tgt, load_val, pc_q;
  logic          accept, is_push, is_pop, load;

  assign kind    = op_kind_e'(op_kind);
  assign accept  = op_valid && !busy;
  assign is_push = (kind == K_CALLP) || (kind == K_CALLL) || (kind == K_INTR);
  assign is_pop  = (kind == K_RET);

  pnu_target #(.DW(DW), .PAGE_W(PAGE_W)) target_i (
    .kind     (kind),
    .pc_inc   (pc_inc),
    .page_fld (op_page),
    .b2       (op_b2),
    .b3       (op_b3),
    .acc      (acc),
    .dptr     (dptr),
    .taken    (taken),
    .vec      (vec),
    .tgt      (tgt)
  );

  pnu_stack_seq #(.DW(DW), .SPW(SPW), .SP_INIT(SP_INIT)) seq_i (
    .clk        (clk),
    .rst        (rst),
    .start_push (accept && is_push),
    .start_pop  (accept && is_pop),
    .ret_in     (pc_inc),
    .tgt_in     (tgt),
    .stk_rdata  (stk_rdata),
    .busy       (busy),
    .load       (load),
    .load_val   (load_val),
    .stk_we     (stk_we),
    .stk_re     (stk_re),
    .stk_addr   (stk_addr),
    .stk_wdata  (stk_wdata),
    .sp         (sp_o)
  );

  always_ff @(posedge clk) begin
    if (rst)                             pc_q <= '0;
    else if (load)                       pc_q <= load_val;
    else if (accept && !is_push && !is_pop) pc_q <= tgt;
  end

  assign pc_o = pc_q;

  // R10: reset clears the program counter
  p_reset_pc_r10: assert property (@(posedge clk) rst |=> (pc_q == '0));

  // R2: a relative branch that is not taken falls through
  p_rel_fallthru_r2: assert property (@(posedge clk) disable iff (rst)
    (accept && kind == K_REL && !taken) |=> (pc_q == $past(pc_inc)));

  // R3: a page jump keeps the upper bits of the incremented PC
  p_page_keep_r3: assert property (@(posedge clk) disable iff (rst)
    (accept && kind == K_PAGE) |=> (pc_q[AW-1:PAGE_W] == $past(pc_inc[AW-1:PAGE_W])));

  // R9: while busy and not loading, the PC does not move
  p_hold_busy_r9: assert property (@(posedge clk) disable iff (rst)
    (busy && !load) |=> $stable(pc_q));
endmodule

// File: tb/pc_next_unit_tb_top.sv
`timescale 1ns/1ps
module pc_next_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        op_valid = 1'b0;
  logic [3:0]  op_kind = 4'd0;
  logic [15:0] pc_inc = 16'h0;
  logic [2:0]  op_page = 3'd0;
  logic [7:0]  op_b2 = 8'h0, op_b3 = 8'h0, acc = 8'h0;
  logic [15:0] dptr = 16'h0, vec = 16'h0;
  logic        taken = 1'b0;
  logic [7:0]  stk_rdata;
  logic [15:0] pc_o;
  logic        busy, stk_we, stk_re;
  logic [7:0]  sp_o, stk_addr, stk_wdata;

  always #4 clk = ~clk;

  pc_next_unit dut_i (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_kind(op_kind),
    .pc_inc(pc_inc), .op_page(op_page), .op_b2(op_b2), .op_b3(op_b3),
    .acc(acc), .dptr(dptr), .taken(taken), .vec(vec),
    .stk_rdata(stk_rdata), .pc_o(pc_o), .busy(busy), .sp_o(sp_o),
    .stk_we(stk_we), .stk_re(stk_re), .stk_addr(stk_addr),
    .stk_wdata(stk_wdata)
  );

  // external synchronous stack memory
  logic [7:0] mem [256];
  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    stk_rdata = 8'h00;
  end
  always @(posedge clk) begin
    if (stk_we) mem[stk_addr] <= stk_wdata;
    if (stk_re) stk_rdata <= mem[stk_addr];
  end

  int checks = 0;
  int fails  = 0;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // reference model: queued future states for stack transfers
  typedef struct { int pc; int sp; bit bz; } st_t;
  st_t   q[$];
  int    m_pc = 0, m_sp = 7;
  bit    m_bz = 0;
  string m_req = "R10";

  function automatic int tgt_of(int k);
    int off;
    off = (op_b2 >= 8'd128) ? int'(op_b2) - 256 : int'(op_b2);
    case (k)
      1: return taken ? ((int'(pc_inc) + off) & 16'hFFFF) : int'(pc_inc);
      2, 5: return (int'(pc_inc) & 16'hF800) | (int'(op_page) << 8) | int'(op_b2);
      3, 6: return int'(op_b2) * 256 + int'(op_b3);
      4: return (int'(dptr) + int'(acc)) & 16'hFFFF;
      8: return int'(vec);
      default: return int'(pc_inc);
    endcase
  endfunction

  always @(posedge clk) begin
    st_t s;
    int  t;
    if (rst) begin
      q.delete();
      m_pc = 0; m_sp = 7; m_bz = 0;
    end else if (q.size() != 0) begin
      s = q.pop_front();
      m_pc = s.pc; m_sp = s.sp; m_bz = s.bz;
    end else if (op_valid) begin
      t = tgt_of(int'(op_kind));
      if (op_kind == 4'd5 || op_kind == 4'd6 || op_kind == 4'd8) begin
        q.push_back('{m_pc, m_sp, 1'b1});
        q.push_back('{m_pc, (m_sp + 1) & 255, 1'b1});
        q.push_back('{t, (m_sp + 2) & 255, 1'b0});
      end else if (op_kind == 4'd7) begin
        t = int'(mem[m_sp]) * 256 + int'(mem[(m_sp - 1) & 255]);
        q.push_back('{m_pc, m_sp, 1'b1});
        q.push_back('{m_pc, (m_sp - 1) & 255, 1'b1});
        q.push_back('{m_pc, (m_sp - 2) & 255, 1'b1});
        q.push_back('{t, (m_sp - 2) & 255, 1'b0});
      end else begin
        q.push_back('{t, m_sp, 1'b0});
      end
      s = q.pop_front();
      m_pc = s.pc; m_sp = s.sp; m_bz = s.bz;
    end
  end

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      chk({m_req, " pc"},   int'(pc_o), m_pc);
      chk({m_req, " sp"},   int'(sp_o), m_sp);
      chk({m_req, " busy"}, int'(busy), int'(m_bz));
    end
  end

  task automatic issue(input logic [3:0] k, input logic [15:0] pi, input string req);
    m_req    = req;
    op_kind  = k;
    pc_inc   = pi;
    op_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    op_valid = 1'b0;
    while (busy) @(negedge clk);
  endtask

  bit done = 0;

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R10: reset state
    chk("R10 pc", int'(pc_o), 0);
    chk("R10 sp", int'(sp_o), 7);
    chk("R10 busy", int'(busy), 0);

    // R11: sequential load and idle hold
    issue(4'd0, 16'h0102, "R11");
    chk("R11 seq", int'(pc_o), 16'h0102);
    m_req = "R11 hold";
    repeat (3) @(negedge clk);
    chk("R11 hold", int'(pc_o), 16'h0102);

    // R1: relative taken, forward, backward extremes and wrap
    taken = 1'b1;
    op_b2 = 8'h05; issue(4'd1, 16'h1000, "R1");
    chk("R1 fwd", int'(pc_o), 16'h1005);
    op_b2 = 8'h80; issue(4'd1, 16'h1000, "R1");
    chk("R1 -128", int'(pc_o), 16'h0F80);
    op_b2 = 8'h7F; issue(4'd1, 16'hFFF0, "R1");
    chk("R1 wrap", int'(pc_o), 16'h006F);
    op_b2 = 8'hF0; issue(4'd1, 16'h0008, "R1");
    chk("R1 wrap down", int'(pc_o), 16'hFFF8);
    // R2: not taken
    taken = 1'b0; op_b2 = 8'h40; issue(4'd1, 16'h2222, "R2");
    chk("R2 fallthru", int'(pc_o), 16'h2222);

    // R3: page jump
    op_page = 3'd5; op_b2 = 8'h3C; issue(4'd2, 16'hA7FF, "R3");
    chk("R3 page", int'(pc_o), 16'hA53C);
    op_page = 3'd7; op_b2 = 8'hFF; issue(4'd2, 16'hF9FE, "R3");
    chk("R3 top", int'(pc_o), 16'hFFFF);

    // R4: long jump
    op_b2 = 8'h12; op_b3 = 8'h34; issue(4'd3, 16'h5555, "R4");
    chk("R4 long", int'(pc_o), 16'h1234);

    // R5: indexed jump with wrap
    dptr = 16'hFFF0; acc = 8'h20; issue(4'd4, 16'h0001, "R5");
    chk("R5 index", int'(pc_o), 16'h0010);

    // R6 + R9: long call with an instruction offered during each busy cycle
    op_b2 = 8'h40; op_b3 = 8'h00;
    m_req = "R6"; op_kind = 4'd6; pc_inc = 16'hBEEF; op_valid = 1'b1;
    @(posedge clk); @(negedge clk);
    m_req = "R9"; op_kind = 4'd3; op_b2 = 8'h77; op_b3 = 8'h66;
    while (busy) @(negedge clk);
    op_valid = 1'b0;
    chk("R6 call target", int'(pc_o), 16'h4000);
    chk("R6 lo at sp+1", int'(mem[8]), 8'hEF);
    chk("R6 hi at sp+2", int'(mem[9]), 8'hBE);
    chk("R9 sp after ignored op", int'(sp_o), 9);

    // R6: page call
    op_page = 3'd2; op_b2 = 8'h10; issue(4'd5, 16'h3456, "R6");
    chk("R6 page call", int'(pc_o), 16'h3210);
    chk("R6 page lo", int'(mem[10]), 8'h56);
    chk("R6 page hi", int'(mem[11]), 8'h34);

    // R8: interrupt entry
    vec = 16'h000B; issue(4'd8, 16'h1357, "R8");
    chk("R8 vector", int'(pc_o), 16'h000B);
    chk("R8 lo", int'(mem[12]), 8'h57);
    chk("R8 hi", int'(mem[13]), 8'h13);

    // R7: returns unwind in reverse order
    issue(4'd7, 16'h0000, "R7");
    chk("R7 ret intr", int'(pc_o), 16'h1357);
    chk("R7 sp", int'(sp_o), 11);
    issue(4'd7, 16'h0000, "R7");
    chk("R7 ret page", int'(pc_o), 16'h3456);
    issue(4'd7, 16'h0000, "R7");
    chk("R7 ret long", int'(pc_o), 16'hBEEF);
    chk("R7 sp home", int'(sp_o), 7);

    // R10: reset in mid-transfer
    issue(4'd0, 16'h0042, "R11");
    m_req = "R10"; op_kind = 4'd6; op_b2 = 8'h99; op_valid = 1'b1;
    @(posedge clk); @(negedge clk);
    op_valid = 1'b0; rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R10 mid pc", int'(pc_o), 0);
    chk("R10 mid sp", int'(sp_o), 7);
    chk("R10 mid busy", int'(busy), 0);
    repeat (2) @(negedge clk);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule